// File: doc/BRIEF.md
# Sparse Bit-Column Group Dot-Product Engine

This engine computes the dot product of a group of G signed activations with G sign-magnitude weights that arrive in compressed form. The weights are never stored whole. A weight's magnitude bits are regrouped by significance, so that the column at significance k holds magnitude bit k of every weight in the group. Columns that are zero for every weight are dropped. An index mask with one bit per significance tells the engine which columns remain, and only those columns are streamed in.

A group starts with a single `start` pulse. That pulse loads the index mask, the per-weight sign bits and the activations. The engine then takes one column per accepted beat, working from the highest present significance down to the lowest. Every lane multiplies its activation by a 1-bit weight bit. The lane's sign bit then decides whether the product is added or subtracted. An adder tree sums the lanes, and the sum is shifted once by the column's significance before it is added to the accumulator. A group with k present columns therefore needs k beats, so sparser weights finish sooner.

The column input is a valid/ready stream. A beat transfers on a rising clock edge at which both `col_valid` and `col_ready` are high. The source may hold `col_valid` low for any number of cycles, and the engine makes no progress while it does. `col_ready` is high exactly while present columns remain to be consumed. `start`, `done` and `result` are plain control and status pins.

Top module: `sbc_group_engine`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `col_ready` is 0.
- R2: A `start` sampled while the engine is idle loads `idx`, `sgn` and `act` and clears the accumulator. If `idx` is non-zero, `col_ready` is high in the following cycle.
- R3: A `start` with an all-zero `idx` makes `done` high in the next cycle with `result` = 0, and no column beat is ever accepted for that group.
- R4: The group consumes exactly as many beats as `idx` has set bits. `col_ready` drops in the cycle after the last beat. At that point `result` equals the sum over lanes i of (sgn[i] ? -1 : +1) * act_i * mag_i, where act_i is the two's-complement value in `act[i*AW +: AW]` and mag_i is the magnitude assembled from the column bits.
- R5: Present columns are taken from the most significant set bit of `idx` down to the least significant. The k-th accepted beat carries the column for the k-th highest set bit, and bit i of `col_bits` is magnitude bit i of weight i.
- R6: A sign bit of 1 in `sgn[i]` subtracts lane i's product in every column of the group. The sign bits are loaded once at start and reused for every column.
- R7: While `col_valid` is low, the engine accepts nothing, keeps `col_ready` high and leaves `result` and the accumulated value unchanged.
- R8: A `start` that arrives while columns are still outstanding is ignored. The running group's index, signs and activations stay in effect.
- R9: `done` is high for one cycle per group. `result` changes only in a cycle in which `done` is high and holds its value until the next group finishes.
- R10: With `col_valid` held high, `done` rises in the cycle after the last beat. A `start` sampled in a `done` cycle is accepted and begins the next group.
- R11: While the engine is idle, `col_ready` is 0, and column beats offered then are not consumed and do not affect any later group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a group when the engine is idle |
| idx | input | MB | Present-column mask, bit k = significance k |
| sgn | input | G | Per-weight sign, 1 = negative |
| act | input | G*AW | Packed signed activations, lane i at [i*AW +: AW] |
| col_valid | input | 1 | Column beat offered |
| col_ready | output | 1 | Engine accepts a column beat |
| col_bits | input | G | Column bits, bit i belongs to weight i |
| result | output | ACCW | Signed dot product of the last finished group |
| done | output | 1 | One-cycle pulse when a group finishes |

## Verification
Two functions can fall in the same cycle: finishing one group and starting the next. The bench raises `start` in the very cycle where `done` reports the previous group. It then checks that the old `result` stays on the pins while the new columns stream, and that the new `result` equals the value computed from the new weights. A second overlap is a `start` pulse with different signs and activations landing on the first column beat of a running group. That case is judged by the group's final result being unchanged.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic {
    SBC_IDLE = 1'b0,
    SBC_RUN  = 1'b1
  } sbc_state_e;

  function automatic int sbc_sum_width(input int aw, input int g);
    return aw + 1 + $clog2(g);
  endfunction

endpackage

// File: rtl/sbc_msb_pick.sv
module sbc_msb_pick #(
  parameter int W = 7,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic [SW-1:0] pos,
  output logic          any
);

  // Scan upward; the highest set bit overwrites the lower ones.
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (mask[i]) pos = SW'(i);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/sbc_col_tree.sv
module sbc_col_tree #(
  parameter int G  = 8,
  parameter int AW = 8,
  localparam int SUMW = AW + 1 + $clog2(G)
) (
  input  logic [G*AW-1:0]        act_flat,
  input  logic [G-1:0]           sgn,
  input  logic [G-1:0]           col,
  output logic signed [SUMW-1:0] sum
);

  localparam int LV = $clog2(G);
  localparam int NP = 1 << LV;

  // Heap-ordered tree: leaves at NP..2*NP-1, root at 1.
  logic signed [SUMW-1:0] node [1:2*NP-1];

  for (genvar l = 0; l < NP; l++) begin : g_leaf
    if (l < G) begin : g_live
      logic signed [AW-1:0]   a;
      logic signed [SUMW-1:0] ext;
      assign a   = act_flat[l*AW +: AW];
      assign ext = SUMW'(a);
      assign node[NP+l] = col[l] ? (sgn[l] ? -ext : ext) : '0;
    end else begin : g_pad
      assign node[NP+l] = '0;
    end
  end

  for (genvar n = 1; n < NP; n++) begin : g_add
    assign node[n] = node[2*n] + node[2*n+1];
  end

  assign sum = node[1];

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
#(
  parameter int MB = 7,
  localparam int SW = (MB > 1) ? $clog2(MB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MB-1:0] idx,
  input  logic          col_valid,
  output logic          col_ready,
  output logic          fire,
  output logic          last,
  output logic [SW-1:0] shift,
  output logic          go,
  output logic          go_empty,
  output logic          done
);

  sbc_state_e    st;
  logic [MB-1:0] rem_q;
  logic [MB-1:0] bit_sel;
  logic          any;
  logic          done_q;

  sbc_msb_pick #(.W(MB)) u_pick (
    .mask (rem_q),
    .pos  (shift),
    .any  (any)
  );

  assign bit_sel   = MB'(1) << shift;
  assign last      = ((rem_q & ~bit_sel) == '0);
  assign col_ready = (st == SBC_RUN) && any;
  assign fire      = col_valid && col_ready;
  assign go        = start && (st == SBC_IDLE);
  assign go_empty  = go && (idx == '0);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SBC_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= go_empty || (fire && last);
      if (go) begin
        rem_q <= idx;
        st    <= (idx == '0) ? SBC_IDLE : SBC_RUN;
      end else if (fire) begin
        rem_q <= rem_q & ~bit_sel;
        if (last) st <= SBC_IDLE;
      end
    end
  end

  // R5: columns are served strictly downward in significance
  a_r5_descending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (col_ready && (shift < $past(shift))));

  // R4: the stream closes right after the final present column
  a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (!col_ready && done));

  // R3: an empty index finishes at once without opening the stream
  a_r3_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    go_empty |=> (done && !col_ready));

endmodule

// File: rtl/sbc_group_engine.sv
module sbc_group_engine #(
  parameter int G    = 8,
  parameter int AW   = 8,
  parameter int MB   = 7,
  parameter int ACCW = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [MB-1:0]          idx,
  input  logic [G-1:0]           sgn,
  input  logic [G*AW-1:0]        act,
  input  logic                   col_valid,
  output logic                   col_ready,
  input  logic [G-1:0]           col_bits,
  output logic signed [ACCW-1:0] result,
  output logic                   done
);

  localparam int SW   = (MB > 1) ? $clog2(MB) : 1;
  localparam int SUMW = sbc_pkg::sbc_sum_width(AW, G);

  logic [G-1:0]           sgn_q;
  logic [G*AW-1:0]        act_q;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_next;
  logic signed [ACCW-1:0] res_q;
  logic signed [SUMW-1:0] col_sum;
  logic [SW-1:0]          shift;
  logic                   fire;
  logic                   last;
  logic                   go;
  logic                   go_empty;

  sbc_seq #(.MB(MB)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .idx       (idx),
    .col_valid (col_valid),
    .col_ready (col_ready),
    .fire      (fire),
    .last      (last),
    .shift     (shift),
    .go        (go),
    .go_empty  (go_empty),
    .done      (done)
  );

  sbc_col_tree #(.G(G), .AW(AW)) u_tree (
    .act_flat (act_q),
    .sgn      (sgn_q),
    .col      (col_bits),
    .sum      (col_sum)
  );

  // One shared shift per column sum, then one accumulate.
  assign acc_next = acc_q + (ACCW'(col_sum) <<< shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q <= '0;
      act_q <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else if (go) begin
      sgn_q <= sgn;
      act_q <= act;
      acc_q <= '0;
      if (go_empty) res_q <= '0;
    end else if (fire) begin
      acc_q <= acc_next;
      if (last) res_q <= acc_next;
    end
  end

  assign result = res_q;

  // R7: a stalled stream leaves the running sum alone
  a_r7_hold_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ready && !col_valid) |=> $stable(acc_q));

  // R8: start during a running group does not reload operands
  a_r8_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ready && start) |=> ($stable(sgn_q) && $stable(act_q)));

  // R9: the visible result moves only together with done
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> done);

endmodule

// File: tb/sbc_group_engine_tb.sv
module sbc_group_engine_tb;

  localparam int G    = 8;
  localparam int AW   = 8;
  localparam int MB   = 7;
  localparam int ACCW = 24;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic [MB-1:0]          idx = '0;
  logic [G-1:0]           sgn = '0;
  logic [G*AW-1:0]        act = '0;
  logic                   col_valid = 1'b0;
  logic                   col_ready;
  logic [G-1:0]           col_bits = '0;
  logic signed [ACCW-1:0] result;
  logic                   done;

  always #10 clk = ~clk;

  sbc_group_engine #(.G(G), .AW(AW), .MB(MB), .ACCW(ACCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .idx(idx), .sgn(sgn),
    .act(act), .col_valid(col_valid), .col_ready(col_ready),
    .col_bits(col_bits), .result(result), .done(done)
  );

  int n_chk = 0;
  int n_err = 0;
  int prev_res = 0;

  logic [MB-1:0]        wm [G];
  logic                 ws [G];
  logic signed [AW-1:0] wa [G];
  logic [MB-1:0]        cur_idx;

  function automatic int exp_dot();
    int s = 0;
    for (int i = 0; i < G; i++) begin
      int v = int'(wa[i]) * int'(wm[i]);
      s = ws[i] ? s - v : s + v;
    end
    return s;
  endfunction

  function automatic logic [MB-1:0] idx_of();
    logic [MB-1:0] m = '0;
    for (int i = 0; i < G; i++) m |= wm[i];
    return m;
  endfunction

  function automatic logic [G-1:0] col_of(input int k);
    logic [G-1:0] c;
    for (int i = 0; i < G; i++) c[i] = wm[i][k];
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic rand_group();
    logic [MB-1:0] keep = MB'($urandom);
    if ($urandom % 8 == 0) keep = '0;
    for (int i = 0; i < G; i++) begin
      wa[i] = AW'($urandom);
      ws[i] = 1'($urandom);
      wm[i] = MB'($urandom) & keep;
    end
  endtask

  // Drive start at a negedge; return at the next negedge.
  task automatic launch();
    cur_idx = idx_of();
    start = 1'b1;
    idx   = cur_idx;
    for (int i = 0; i < G; i++) begin
      sgn[i] = ws[i];
      act[i*AW +: AW] = wa[i];
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  // Stream present columns MSB first; returns at the negedge after the last beat.
  task automatic feed(input int gap_pct, input bit poke);
    int cnt = 0;
    for (int k = MB - 1; k >= 0; k--) begin
      if (cur_idx[k]) begin
        while (($urandom % 100) < gap_pct) begin
          col_valid = 1'b0;
          col_bits  = G'($urandom);
          @(negedge clk);
          chk(!done && result == prev_res, "R7 stall kept result", result, prev_res);
          chk(col_ready == 1'b1, "R7 ready held during stall", int'(col_ready), 1);
        end
        chk(col_ready == 1'b1, "R2 ready while columns remain", int'(col_ready), 1);
        chk(result == prev_res, "R9 result held mid-group", result, prev_res);
        col_valid = 1'b1;
        col_bits  = col_of(k);
        if (poke && cnt == 0) begin
          start = 1'b1;
          idx   = MB'($urandom) | 1;
          sgn   = ~sgn;
          act   = {G{AW'($urandom)}};
        end
        @(negedge clk);
        start = 1'b0;
        col_valid = 1'b0;
        cnt++;
      end
    end
  endtask

  task automatic run_one(input int gap, input bit poke, input bit chain, input string tag);
    int e = exp_dot();
    launch();
    if (cur_idx == '0) begin
      chk(done == 1'b1, "R3 empty index done", int'(done), 1);
      chk(result == 0, "R3 empty index result", result, 0);
      chk(col_ready == 1'b0, "R3 no column taken", int'(col_ready), 0);
    end else begin
      chk(done == 1'b0, "R10 no early done", int'(done), 0);
      feed(gap, poke);
      chk(col_ready == 1'b0, "R4 ready drops after last", int'(col_ready), 0);
      chk(done == 1'b1, "R10 done after last beat", int'(done), 1);
      chk(result == e, tag, result, e);
    end
    prev_res = e;
    if (!chain) begin
      @(negedge clk);
      chk(done == 1'b0, "R9 done single pulse", int'(done), 0);
      chk(result == e, "R9 result holds", result, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(result == 0, "R1 reset result", result, 0);
    chk(col_ready == 1'b0, "R1 reset ready", int'(col_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: beats offered while idle are refused
    for (int c = 0; c < 4; c++) begin
      col_valid = 1'b1;
      col_bits  = '1;
      @(negedge clk);
      chk(col_ready == 1'b0, "R11 idle refuses beats", int'(col_ready), 0);
    end
    col_valid = 1'b0;

    // R3: empty group
    for (int i = 0; i < G; i++) begin wm[i] = '0; ws[i] = 1'b0; wa[i] = 8'sd5; end
    run_one(0, 1'b0, 1'b0, "R3 empty");

    // R5: order sensitive pair, 66 if MSB first, 129 if reversed
    for (int i = 0; i < G; i++) begin wm[i] = '0; ws[i] = 1'b0; wa[i] = AW'(i + 1); end
    wm[0] = 7'b1000000;
    wm[1] = 7'b0000001;
    run_one(0, 1'b0, 1'b0, "R5 msb-first result");
    chk(prev_res == 66, "R5 expected order value", prev_res, 66);

    // R6: all negative signs, extreme magnitudes and activations
    for (int i = 0; i < G; i++) begin wm[i] = 7'h7f; ws[i] = 1'b1; wa[i] = -8'sd128; end
    run_one(0, 1'b0, 1'b0, "R6 negative signs extreme");

    // R6: mixed signs on a single column
    for (int i = 0; i < G; i++) begin wm[i] = 7'b0001000; ws[i] = 1'(i); wa[i] = AW'(10 * i - 30); end
    run_one(2, 1'b0, 1'b0, "R6 mixed signs one column");

    // R8: start during the first beat is ignored
    rand_group();
    wm[0] = 7'h55;
    run_one(30, 1'b1, 1'b0, "R8 busy start ignored");

    // R10: back-to-back groups, start in the done cycle
    rand_group();
    wm[2] = 7'h3;
    run_one(0, 1'b0, 1'b1, "R10 first of chain");
    rand_group();
    wm[3] = 7'h60;
    run_one(0, 1'b0, 1'b0, "R10 second of chain");

    // R4, R7: random groups with stalls and occasional chaining
    for (int g = 0; g < 150; g++) begin
      rand_group();
      run_one(int'($urandom % 50), 1'($urandom % 6 == 0), 1'($urandom % 4 == 0), "R4 random result");
    end
    @(negedge clk);

    summary();
    $finish;
  end

endmodule